// File: doc/BRIEF.md
# Banked Memory with Lane-Gated, Rotated and Byte-Masked Dual-Rail Read

This block is a 128-kilobit synchronous store. It is built from four banks, and each bank holds 256 words of 128 bits. A single write port stores one word per clock. The read path takes one bank's word and shapes it in three steps, always in this order:

1. Each 32-bit lane is either kept or forced to zero.
2. The word is rotated left by a whole number of bytes.
3. Every byte outside an inclusive begin..end window is cleared.

The shaped word leaves the block on a pair of rails. One rail carries the word and the other carries its complement. A qualifying strobe can pull both rails low.

A read takes two clock edges. On the first edge, write enable is low and the block takes the address, lane enables and rotation amount. On the second edge it takes the byte window, and the shaped result appears after that edge. A write that lands on that second edge at the address being read is forwarded into the result. This gives the reader the newest data.

Top module: `lane_mem_top`

## Requirements
- R1: A write (wrEn high at a rising clock) stores wrData at addr. Address bits [9:8] pick the bank and bits [7:0] pick the row. A later read of that address returns the stored word until another write to the same address occurs.
- R2: A read begins at a rising edge where wrEn is low and no read is already pending. That edge samples addr, driveEn and alignAmt. The next rising edge samples beginIdx and endIdx and updates the result. Values of driveEn and alignAmt on the second edge have no effect.
- R3: Bit i of the read word is zeroed when driveEn[i/32] is 0, so driveEn[k] governs bits 32k..32k+31. Gating is applied before rotation.
- R4: After gating, the word is rotated left by 8*alignAmt bits. Output byte b takes input byte (b - alignAmt) mod 16, where byte b is bits 8b+7..8b.
- R5: After rotation, byte b is kept when beginIdx <= b <= endIdx and is zero otherwise.
- R6: When beginIdx > endIdx, the whole result is zero.
- R7: While alignValid is high, outHi equals the result and outLo equals its bitwise complement. While alignValid is low, both rails are all zeros.
- R8: No bit is ever high on outHi and outLo at the same time.
- R9: If the second edge of a read is also a write to the address being read, the result uses the new wrData. A write to a different address on that edge does not alter the result.
- R10: The result holds its value at every edge that does not complete a read.
- R11: After reset the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write enable; low starts a read |
| addr | input | 10 | Bank (upper 2 bits) and row |
| wrData | input | 128 | Data to store |
| driveEn | input | 4 | Per-lane enables, one per 32 bits |
| alignAmt | input | 4 | Left rotation in bytes |
| beginIdx | input | 4 | First kept byte |
| endIdx | input | 4 | Last kept byte |
| alignValid | input | 1 | Qualifies the output rails |
| outHi | output | 128 | True rail of the result |
| outLo | output | 128 | Complement rail of the result |

## Verification
The embedded properties check four things on every cycle: the rails are mutually exclusive, and under alignValid they are exact complements; completions never occur on two edges in a row; the result does not move between completions; and an inverted byte window always clears the result. Other behaviours show up only in the bench's scenarios, because a property would need the stored contents to check them. These are the bank and row decode, the ordering of gating ahead of rotation, the exact byte window, and forwarding on a colliding write. The bench computes each of these from its own model of memory and compares it with the rails.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  typedef struct packed {
    logic capture;  // first edge of a read: fetch the row, hold its controls
    logic finish;   // second edge: take the byte window, update the result
    logic bypass;   // finish edge collides with a write to the held address
  } rdStrobe_t;
endpackage

// File: rtl/lane_mem_ctrl.sv
module lane_mem_ctrl
  import lane_mem_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DRV_W   = 4,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DRV_W-1:0]   driveEn,
  input  logic [SHIFT_W-1:0] alignAmt,
  output rdStrobe_t          strb,
  output logic [DRV_W-1:0]   heldDrive,
  output logic [SHIFT_W-1:0] heldAlign
);
  logic              pending;
  logic [ADDR_W-1:0] heldAddr;

  always_comb begin
    strb.capture = !wrEn && !pending;
    strb.finish  = pending;
    strb.bypass  = pending && wrEn && (addr == heldAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strb.capture) begin
      pending <= 1'b1;
    end else begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldDrive <= '0;
      heldAlign <= '0;
    end else if (strb.capture) begin
      heldAddr  <= addr;
      heldDrive <= driveEn;
      heldAlign <= alignAmt;
    end
  end

  // R2: a read occupies two edges, so completions never come back to back
  a_r2_no_double_finish: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !strb.finish);
endmodule

// File: rtl/lane_mem_data.sv
module lane_mem_data
  import lane_mem_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROWS  = 256,
  parameter int WORD  = 128,
  parameter int LANE  = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  rdStrobe_t                         strb,
  input  logic                              wrEn,
  input  logic [$clog2(BANKS*ROWS)-1:0]     addr,
  input  logic [WORD-1:0]                   wrData,
  input  logic [WORD/LANE-1:0]              heldDrive,
  input  logic [$clog2(WORD/8)-1:0]         heldAlign,
  input  logic [$clog2(WORD/8)-1:0]         beginIdx,
  input  logic [$clog2(WORD/8)-1:0]         endIdx,
  output logic [WORD-1:0]                   resultWord
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int ADDR_W = BANK_W + ROW_W;
  localparam int LANES  = WORD / LANE;
  localparam int NBYTES = WORD / 8;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int SH_W   = $clog2(WORD) + 1;

  logic [BANK_W-1:0] bankSel;
  logic [ROW_W-1:0]  rowSel;
  logic [BANK_W-1:0] rdBank;
  logic [BANKS-1:0][WORD-1:0] bankRdAll;

  assign bankSel = addr[ADDR_W-1 -: BANK_W];
  assign rowSel  = addr[ROW_W-1:0];

  for (genvar bk = 0; bk < BANKS; bk++) begin : g_bank
    logic [WORD-1:0] cells [ROWS];
    logic [WORD-1:0] bankQ;
    always_ff @(posedge clk) begin
      if (wrEn && bankSel == BANK_W'(bk)) cells[rowSel] <= wrData;
    end
    always_ff @(posedge clk) begin
      if (strb.capture && bankSel == BANK_W'(bk)) bankQ <= cells[rowSel];
    end
    assign bankRdAll[bk] = bankQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdBank <= '0;
    else if (strb.capture) rdBank <= bankSel;
  end

  // forwarding of a colliding write, then lane gating
  logic [WORD-1:0] srcWord, gated, rotated, masked;
  assign srcWord = strb.bypass ? wrData : bankRdAll[rdBank];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign gated[LANE*ln +: LANE] = heldDrive[ln] ? srcWord[LANE*ln +: LANE] : '0;
  end

  // byte-granular left rotation
  logic [SH_W-1:0] shAmt, backAmt;
  assign shAmt   = {heldAlign, 3'b000};
  assign backAmt = SH_W'(WORD) - shAmt;
  assign rotated = (gated << shAmt) | (gated >> backAmt);

  // inclusive byte window
  for (genvar by = 0; by < NBYTES; by++) begin : g_byte
    logic keep;
    assign keep = (IDX_W'(by) >= beginIdx) && (IDX_W'(by) <= endIdx);
    assign masked[8*by +: 8] = keep ? rotated[8*by +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultWord <= '0;
    else if (strb.finish) resultWord <= masked;
  end

  a_r10_hold_between_reads: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(resultWord));

  a_r6_inverted_window_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && beginIdx > endIdx) |=> resultWord == '0);
endmodule

// File: rtl/lane_mem_top.sv
module lane_mem_top
  import lane_mem_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROWS  = 256,
  parameter int WORD  = 128,
  parameter int LANE  = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [$clog2(BANKS*ROWS)-1:0] addr,
  input  logic [WORD-1:0]               wrData,
  input  logic [WORD/LANE-1:0]          driveEn,
  input  logic [$clog2(WORD/8)-1:0]     alignAmt,
  input  logic [$clog2(WORD/8)-1:0]     beginIdx,
  input  logic [$clog2(WORD/8)-1:0]     endIdx,
  input  logic                          alignValid,
  output logic [WORD-1:0]               outHi,
  output logic [WORD-1:0]               outLo
);
  localparam int ADDR_W  = $clog2(BANKS*ROWS);
  localparam int DRV_W   = WORD / LANE;
  localparam int SHIFT_W = $clog2(WORD/8);

  rdStrobe_t           strb;
  logic [DRV_W-1:0]    heldDrive;
  logic [SHIFT_W-1:0]  heldAlign;
  logic [WORD-1:0]     resultWord;

  lane_mem_ctrl #(.ADDR_W(ADDR_W), .DRV_W(DRV_W), .SHIFT_W(SHIFT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .driveEn(driveEn),
    .alignAmt(alignAmt), .strb(strb), .heldDrive(heldDrive), .heldAlign(heldAlign)
  );

  lane_mem_data #(.BANKS(BANKS), .ROWS(ROWS), .WORD(WORD), .LANE(LANE)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .heldDrive(heldDrive), .heldAlign(heldAlign), .beginIdx(beginIdx),
    .endIdx(endIdx), .resultWord(resultWord)
  );

  assign outHi = alignValid ? resultWord  : '0;
  assign outLo = alignValid ? ~resultWord : '0;

  a_r8_rails_mutex: assert property (@(posedge clk) disable iff (!rstN)
    (outHi & outLo) == '0);

  a_r7_rails_complement: assert property (@(posedge clk) disable iff (!rstN)
    alignValid |-> (outHi ^ outLo) == '1);
endmodule

// File: tb/lane_mem_top_tb_top.sv
module lane_mem_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b1;
  logic [9:0]   addr = '0;
  logic [127:0] wrData = '0;
  logic [3:0]   driveEn = '0;
  logic [3:0]   alignAmt = '0;
  logic [3:0]   beginIdx = '0;
  logic [3:0]   endIdx = '0;
  logic         alignValid = 1'b0;
  logic [127:0] outHi, outLo;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [127:0] model [1024];
  logic [127:0] lastExp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_mem_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .driveEn(driveEn), .alignAmt(alignAmt), .beginIdx(beginIdx), .endIdx(endIdx),
    .alignValid(alignValid), .outHi(outHi), .outLo(outLo)
  );

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [9:0] poolAddr(int i);
    logic [3:0] v = 4'(i);
    return {v[1:0], 2'b00, v, 2'b01};
  endfunction

  // gating, then byte rotation, then inclusive window
  function automatic logic [127:0] shape(logic [127:0] w, logic [3:0] drv,
                                         logic [3:0] al, logic [3:0] bg, logic [3:0] en);
    logic [127:0] g, r, m;
    for (int k = 0; k < 4; k++) g[32*k +: 32] = drv[k] ? w[32*k +: 32] : 32'h0;
    for (int b = 0; b < 16; b++) r[8*b +: 8] = g[8*((b - int'(al) + 16) % 16) +: 8];
    for (int b = 0; b < 16; b++) m[8*b +: 8] = (b >= int'(bg) && b <= int'(en)) ? r[8*b +: 8] : 8'h0;
    return m;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [9:0] a, logic [127:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    driveEn = 4'($urandom); alignAmt = 4'($urandom);
    beginIdx = 4'($urandom); endIdx = 4'($urandom);
    @(negedge clk);
    model[a] = d;
  endtask

  // R2: phase-two values of driveEn/alignAmt and phase-one begin/end are scrambled
  task automatic doRead(logic [9:0] a, logic [3:0] drv, logic [3:0] al, logic [3:0] bg,
                        logic [3:0] en, bit wr2, logic [9:0] a2, logic [127:0] d2,
                        bit av, string req);
    logic [127:0] src;
    wrEn = 1'b0; addr = a; driveEn = drv; alignAmt = al;
    beginIdx = ~bg; endIdx = ~en;
    @(negedge clk);
    src = (wr2 && a2 == a) ? d2 : model[a];
    wrEn = wr2; addr = wr2 ? a2 : ~a; wrData = d2;
    driveEn = ~drv; alignAmt = ~al; beginIdx = bg; endIdx = en;
    @(negedge clk);
    if (wr2) model[a2] = d2;
    wrEn = 1'b1; addr = 10'h3ff; wrData = model[10'h3ff];
    lastExp = shape(src, drv, al, bg, en);
    alignValid = av;
    #1;
    if (av) begin
      chk(req, outHi, lastExp);
      chk(req, outLo, ~lastExp);
    end else begin
      chk({req, " R7 quiet"}, outHi | outLo, 128'h0);
    end
    alignValid = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 / R7 reset state
    #1;
    chk("R11 R7 reset quiet", outHi | outLo, 128'h0);
    alignValid = 1'b1; #1;
    chk("R11 reset hi", outHi, 128'h0);
    chk("R11 reset lo", outLo, '1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) doWrite(poolAddr(i), rnd128());
    doWrite(10'h3ff, rnd128());

    // R1: same row, four banks
    for (int b = 0; b < 4; b++) doWrite({2'(b), 8'h05}, {4{32'(b * 32'h11111111 + 32'h0badf00d)}} ^ rnd128());
    for (int b = 0; b < 4; b++) doRead({2'(b), 8'h05}, 4'hf, 4'h0, 4'h0, 4'hf, 0, 10'h0, '0, 1, "R1 bank decode");

    doRead(poolAddr(3), 4'b0101, 4'h0, 4'h0, 4'hf, 0, 10'h0, '0, 1, "R3 lane gating");
    doRead(poolAddr(4), 4'b0001, 4'h3, 4'h0, 4'hf, 0, 10'h0, '0, 1, "R4 rotate after gate");
    doRead(poolAddr(5), 4'hf, 4'hf, 4'h0, 4'hf, 0, 10'h0, '0, 1, "R4 max rotate");
    doRead(poolAddr(6), 4'hf, 4'h0, 4'h2, 4'h9, 0, 10'h0, '0, 1, "R5 window");
    doRead(poolAddr(6), 4'hf, 4'h0, 4'h7, 4'h7, 0, 10'h0, '0, 1, "R5 single byte");
    doRead(poolAddr(7), 4'hf, 4'h1, 4'h9, 4'h2, 0, 10'h0, '0, 1, "R6 inverted window");
    chk("R6 zero", outHi, 128'h0);
    doRead(poolAddr(8), 4'hf, 4'h0, 4'h0, 4'hf, 0, 10'h0, '0, 0, "R7 alignValid low");

    // R9 forwarding
    d = rnd128();
    doRead(poolAddr(9), 4'hf, 4'h2, 4'h1, 4'he, 1, poolAddr(9), d, 1, "R9 bypass same address");
    d = rnd128();
    doRead(poolAddr(10), 4'hf, 4'h0, 4'h0, 4'hf, 1, poolAddr(11), d, 1, "R9 other address no bypass");
    doRead(poolAddr(11), 4'hf, 4'h0, 4'h0, 4'hf, 0, 10'h0, '0, 1, "R1 read back after write");

    // R10 hold across non-read edges
    doRead(poolAddr(12), 4'hf, 4'h5, 4'h3, 4'hc, 0, 10'h0, '0, 1, "R10 setup");
    for (int k = 0; k < 3; k++) begin
      doWrite(poolAddr(13), rnd128());
      #1;
      chk("R10 hold", outHi, lastExp);
    end

    // random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        doWrite(poolAddr($urandom_range(0, 15)), rnd128());
      end else begin
        logic [9:0] ra, wa;
        bit w2;
        ra = poolAddr($urandom_range(0, 15));
        w2 = ($urandom_range(0, 3) == 0);
        wa = ($urandom_range(0, 1) == 0) ? ra : poolAddr($urandom_range(0, 15));
        doRead(ra, 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
               w2, wa, rnd128(), ($urandom_range(0, 7) != 0), "R2 R3 R4 R5 R9 random");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule